// File: doc/BRIEF.md
# Dual-Source Reload Down-Counter

This block is a 16-bit down-counter with its own reload register. It is set up through a small byte-wide register bus. It can take its count pulses from one of three prescaled internal tick enables, or from a chosen edge of an external event pin. The count wraps from 0000h to FFFFh, and that wrap is the underflow. A period from a load therefore lasts reload+1 count events.

On underflow the counter does one of two things:
- In reload mode it reloads itself and keeps counting.
- In one-shot mode it parks at FFFFh and stops.

Every underflow sets a sticky status flag. The flag can raise an interrupt line. An output pin can either toggle once per period or stay active for the length of a one-shot run.

Software loads the reload value with two byte writes. It then starts the counter by writing the control byte with both the start bit and the enable bit set. The block has no streaming data path: the register bus is a plain single-cycle write strobe with a combinational read mux, so no back-pressure applies. The tick inputs, event pin, output pin and interrupt line are plain level or strobe pins.

Top module: `reload_down_timer`

## Requirements
- R1: After reset, both control bytes (address 0 and address 1) read 00h, `irq` is 0 and `out_pin` is 0.
- R2: The register map is as follows.
  - Address 2 is the count/reload low byte and address 3 is the high byte.
  - Writes to addresses 2 and 3 go to the reload register. Reads from them return the live counter.
  - Control low byte (address 0): bit0 start, bit1 count enable, bit2 underflow flag, bit3 interrupt enable, bit4 reload mode, bit5 output invert, bit6 output enable, bit7 edge select low bit.
  - Control high byte (address 1): bit0 edge select high bit, bit1 spare storage bit, bits3:2 source select. Bits 7:4 read 0.
- R3: A write of the control low byte with both bit0 and bit1 set loads the reload value into the counter and starts counting. Bit0 always reads back as 0.
- R4: While running, the counter decrements by one in each cycle where the selected source strobes. Source select 00, 01 or 10 picks `tick_in[0]`, `tick_in[1]` or `tick_in[2]`. Strobes on the unselected tick inputs have no effect on the count.
- R5: Underflow is the step from 0000h. In reload mode (bit4 = 1) the counter then reloads and keeps running, so underflows come every reload+1 counts.
- R6: In one-shot mode (bit4 = 0) an underflow leaves the counter at FFFFh and stopped. Further strobes do not change it.
- R7: Each underflow sets the flag (control low bit2). Writing 0 to that bit clears it, and writing 1 leaves it unchanged. `irq` is high exactly while the flag and the interrupt enable are both 1.
- R8: Source select 11 is event mode, where the count source is an edge on `evt_pin` after a two-flop synchronizer. The edge select field {high bit0, low bit7} picks the edge: 00 none, 01 rising, 10 falling, 11 both.
- R9: The output pin behaves as follows.
  - When output enable is 0, `out_pin` is 0.
  - When output enable is 1 in reload mode, the level toggles on each underflow, starting from 0 at the start write.
  - When output enable is 1 in one-shot mode, the level is 1 while the counter runs.
  - Output invert flips the enabled level.
- R10: Writing the control low byte with bit1 = 0 stops the counter and keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 2 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| tick_in | input | 3 | Prescaled internal count enables |
| evt_pin | input | 1 | External event input (asynchronous) |
| out_pin | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request |

## Verification
A register write is visible on `reg_rdata` in the cycle after its strobe edge. A tick strobe that is high at an edge changes the count at that same edge. The flag, `irq` and `out_pin` follow on that edge too, because they are registers or direct decodes of registers. An `evt_pin` change takes three edges: two synchronizer flops plus the edge-history flop, and the count moves on the third. The bench drives every input on the falling edge and samples in the low half-cycle. It waits one cycle after a tick and four cycles after an event pin change before it compares, so each read lands after the result is due and before the next stimulus.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_TICK = 3;

  // control low byte bit positions
  localparam int unsigned B_START = 0;
  localparam int unsigned B_CEN   = 1;
  localparam int unsigned B_FLAG  = 2;
  localparam int unsigned B_IEN   = 3;
  localparam int unsigned B_RLD   = 4;
  localparam int unsigned B_OINV  = 5;
  localparam int unsigned B_OEN   = 6;
  localparam int unsigned B_EDG0  = 7;
  // control high byte bit positions
  localparam int unsigned H_EDG1  = 0;
  localparam int unsigned H_SPARE = 1;
  localparam int unsigned H_SRC0  = 2;
  localparam int unsigned H_SRC1  = 3;

  localparam logic [1:0] ADDR_CTL_LO = 2'd0;
  localparam logic [1:0] ADDR_CTL_HI = 2'd1;
  localparam logic [1:0] ADDR_CNT_LO = 2'd2;
  localparam logic [1:0] ADDR_CNT_HI = 2'd3;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_e;

  localparam logic [1:0] SRC_EVENT = 2'b11;
endpackage

// File: rtl/rdt_edge_det.sv
module rdt_edge_det
  import rdt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin,
  input  edge_e sel,
  output logic  evt
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic                   rise, fall;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= sync_q[LAST];
  end

  assign rise = sync_q[LAST] & ~hist_q;
  assign fall = ~sync_q[LAST] & hist_q;

  always_comb begin
    unique case (sel)
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      EDGE_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end

  // R8
  rise_not_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  // R8
  none_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == EDGE_NONE) |-> !evt);
endmodule

// File: rtl/rdt_regs.sv
module rdt_regs
  import rdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              underflow,
  output logic [CNT_W-1:0]  reload_val,
  output logic              load,
  output logic              stop,
  output logic              rld_mode,
  output logic              out_en,
  output logic              out_inv,
  output edge_e             edge_sel,
  output logic [1:0]        src_sel,
  output logic              irq
);
  logic cen_q, flag_q, ien_q, rld_q, oinv_q, oen_q, edg0_q;
  logic edg1_q, spare_q;
  logic [1:0] src_q;
  logic [CNT_W-1:0] rld_val_q;
  logic wr_lo, wr_hi, wr_clo, wr_chi;

  assign wr_clo = reg_wr && (reg_addr == ADDR_CTL_LO);
  assign wr_chi = reg_wr && (reg_addr == ADDR_CTL_HI);
  assign wr_lo  = reg_wr && (reg_addr == ADDR_CNT_LO);
  assign wr_hi  = reg_wr && (reg_addr == ADDR_CNT_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cen_q  <= 1'b0; ien_q  <= 1'b0; rld_q <= 1'b0;
      oinv_q <= 1'b0; oen_q  <= 1'b0; edg0_q <= 1'b0;
    end else if (wr_clo) begin
      cen_q  <= reg_wdata[B_CEN];
      ien_q  <= reg_wdata[B_IEN];
      rld_q  <= reg_wdata[B_RLD];
      oinv_q <= reg_wdata[B_OINV];
      oen_q  <= reg_wdata[B_OEN];
      edg0_q <= reg_wdata[B_EDG0];
    end
  end

  // sticky flag: a new underflow wins over a clearing write
  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (underflow) flag_q <= 1'b1;
    else if (wr_clo && !reg_wdata[B_FLAG]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edg1_q <= 1'b0; spare_q <= 1'b0; src_q <= 2'b00;
    end else if (wr_chi) begin
      edg1_q  <= reg_wdata[H_EDG1];
      spare_q <= reg_wdata[H_SPARE];
      src_q   <= {reg_wdata[H_SRC1], reg_wdata[H_SRC0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rld_val_q <= '0;
    else begin
      if (wr_lo) rld_val_q[BYTE_W-1:0]     <= reg_wdata;
      if (wr_hi) rld_val_q[CNT_W-1:BYTE_W] <= reg_wdata;
    end
  end

  assign load       = wr_clo && reg_wdata[B_START] && reg_wdata[B_CEN];
  assign stop       = wr_clo && !reg_wdata[B_CEN];
  assign reload_val = rld_val_q;
  assign rld_mode   = rld_q;
  assign out_en     = oen_q;
  assign out_inv    = oinv_q;
  assign edge_sel   = edge_e'({edg1_q, edg0_q});
  assign src_sel    = src_q;
  assign irq        = flag_q & ien_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTL_LO: begin
        reg_rdata[B_START] = 1'b0;
        reg_rdata[B_CEN]   = cen_q;
        reg_rdata[B_FLAG]  = flag_q;
        reg_rdata[B_IEN]   = ien_q;
        reg_rdata[B_RLD]   = rld_q;
        reg_rdata[B_OINV]  = oinv_q;
        reg_rdata[B_OEN]   = oen_q;
        reg_rdata[B_EDG0]  = edg0_q;
      end
      ADDR_CTL_HI: begin
        reg_rdata[H_EDG1]  = edg1_q;
        reg_rdata[H_SPARE] = spare_q;
        reg_rdata[H_SRC0]  = src_q[0];
        reg_rdata[H_SRC1]  = src_q[1];
      end
      ADDR_CNT_LO: reg_rdata = count[BYTE_W-1:0];
      default:     reg_rdata = count[CNT_W-1:BYTE_W];
    endcase
  end

  // R7
  flag_rise_from_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(underflow));
  // R7
  flag_set_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && wr_clo && reg_wdata[B_FLAG]) |=> flag_q);
endmodule

// File: rtl/rdt_core.sv
module rdt_core
  import rdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stop,
  input  logic             tick,
  input  logic             rld_mode,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             underflow,
  output logic             out_lvl
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, tgl_q, step, at_zero;

  assign step      = run_q && tick && !load && !stop;
  assign at_zero   = (cnt_q == '0);
  assign underflow = step && at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      tgl_q <= 1'b0;
    end else if (load) begin
      cnt_q <= reload_val;
      run_q <= 1'b1;
      tgl_q <= 1'b0;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (step) begin
      if (at_zero) begin
        tgl_q <= ~tgl_q;
        if (rld_mode) begin
          cnt_q <= reload_val;
        end else begin
          cnt_q <= '1;
          run_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
  assign out_lvl = rld_mode ? tgl_q : run_q;

  // R6
  oneshot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !rld_mode) |=> (!run_q && cnt_q == '1));
  // R5
  reload_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && rld_mode) |=> run_q);
  // R10
  idle_count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load) |=> $stable(cnt_q));
  // R4
  step_decrements_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
  import rdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [2:0] tick_in,
  input  logic       evt_pin,
  output logic       out_pin,
  output logic       irq
);
  logic [CNT_W-1:0] count, reload_val;
  logic load, stop, rld_mode, out_en, out_inv, running, underflow, out_lvl;
  logic evt, src_tick;
  logic [1:0] src_sel;
  edge_e edge_sel;

  rdt_regs u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .count, .underflow, .reload_val, .load, .stop, .rld_mode,
    .out_en, .out_inv, .edge_sel, .src_sel, .irq
  );

  rdt_edge_det #(.SYNC_STAGES(2)) u_edge (
    .clk, .rst_n, .pin(evt_pin), .sel(edge_sel), .evt
  );

  always_comb begin
    unique case (src_sel)
      2'b00:   src_tick = tick_in[0];
      2'b01:   src_tick = tick_in[1];
      2'b10:   src_tick = tick_in[2];
      default: src_tick = evt;
    endcase
  end

  rdt_core u_core (
    .clk, .rst_n, .load, .stop, .tick(src_tick), .rld_mode, .reload_val,
    .count, .running, .underflow, .out_lvl
  );

  assign out_pin = out_en & (out_lvl ^ out_inv);

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(underflow) || $past(reg_wr)));
  // R9
  out_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !out_pin);
endmodule

// File: tb/tb_reload_down_timer.sv
module tb_reload_down_timer;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, evt_pin = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [2:0] tick_in = '0;
  logic out_pin, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reload_down_timer dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd2, lo); rd(2'd3, hi); v = {hi, lo};
  endtask

  task automatic tick(int idx, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in[idx] = 1'b1;
      @(negedge clk); tick_in = '0;
    end
  endtask

  task automatic set_pin(logic v);
    @(negedge clk); evt_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_reload(logic [15:0] v);
    wr(2'd2, v[7:0]); wr(2'd3, v[15:8]);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk("R1 ctl lo", d, 8'h00);
    rd(2'd1, d); chk("R1 ctl hi", d, 8'h00);
    chk("R1 irq", irq, 0); chk("R1 out_pin", out_pin, 0);
  endtask

  task automatic t_start;
    logic [15:0] v; logic [7:0] d;
    wr(2'd1, 8'h06); rd(2'd1, d); chk("R2 hi readback", d, 8'h06);
    wr(2'd1, 8'h04);
    load_reload(16'h1234);
    rd_cnt(v); chk("R3 no load before start", v, 16'h0000);
    wr(2'd0, 8'h03);
    rd_cnt(v); chk("R3 load on start", v, 16'h1234);
    rd(2'd0, d); chk("R3 start reads 0", d, 8'h02);
  endtask

  task automatic t_select;
    logic [15:0] v;
    tick(1, 3); rd_cnt(v); chk("R4 selected ticks", v, 16'h1231);
    tick(0, 2); tick(2, 2); rd_cnt(v); chk("R4 other ticks ignored", v, 16'h1231);
  endtask

  task automatic t_reload;
    logic [15:0] v; logic [7:0] d;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    load_reload(16'h0002);
    wr(2'd0, 8'h13);
    tick(0, 2); rd(2'd0, d); chk("R5 no flag before period", d[2], 0);
    tick(0, 1); rd(2'd0, d); chk("R5 flag after reload+1", d[2], 1);
    rd_cnt(v); chk("R5 reloaded", v, 16'h0002);
    tick(0, 1); rd_cnt(v); chk("R5 keeps running", v, 16'h0001);
  endtask

  task automatic t_oneshot_flag;
    logic [15:0] v; logic [7:0] d;
    wr(2'd0, 8'h00); load_reload(16'h0001);
    wr(2'd0, 8'h0B);
    tick(0, 2); rd_cnt(v); chk("R6 parks at FFFF", v, 16'hFFFF);
    tick(0, 3); rd_cnt(v); chk("R6 stays stopped", v, 16'hFFFF);
    chk("R7 irq high", irq, 1);
    wr(2'd0, 8'h0C); rd(2'd0, d); chk("R7 write 1 keeps flag", d[2], 1);
    wr(2'd0, 8'h08); rd(2'd0, d); chk("R7 write 0 clears", d[2], 0);
    chk("R7 irq low", irq, 0);
  endtask

  task automatic t_event;
    logic [15:0] v;
    wr(2'd0, 8'h00); wr(2'd1, 8'h0C); load_reload(16'h000A);
    wr(2'd0, 8'h83);
    set_pin(1); rd_cnt(v); chk("R8 rising counts", v, 16'h0009);
    set_pin(0); rd_cnt(v); chk("R8 falling ignored in rise", v, 16'h0009);
    wr(2'd1, 8'h0D); wr(2'd0, 8'h02);
    set_pin(1); rd_cnt(v); chk("R8 rising ignored in fall", v, 16'h0009);
    set_pin(0); rd_cnt(v); chk("R8 falling counts", v, 16'h0008);
    wr(2'd0, 8'h82);
    set_pin(1); set_pin(0); rd_cnt(v); chk("R8 both edges", v, 16'h0006);
    wr(2'd1, 8'h0C); wr(2'd0, 8'h02);
    set_pin(1); set_pin(0); rd_cnt(v); chk("R8 none mode", v, 16'h0006);
    tick(0, 2); rd_cnt(v); chk("R8 ticks ignored in event mode", v, 16'h0006);
  endtask

  task automatic t_output;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); load_reload(16'h0000);
    wr(2'd0, 8'h53);
    chk("R9 toggle starts low", out_pin, 0);
    tick(0, 1); chk("R9 toggle 1", out_pin, 1);
    tick(0, 1); chk("R9 toggle 2", out_pin, 0);
    wr(2'd0, 8'h72); chk("R9 invert", out_pin, 1);
    wr(2'd0, 8'h12); chk("R9 disabled", out_pin, 0);
    load_reload(16'h0001);
    wr(2'd0, 8'h43); chk("R9 oneshot active", out_pin, 1);
    tick(0, 2); chk("R9 oneshot ends", out_pin, 0);
  endtask

  task automatic t_stop;
    logic [15:0] v;
    load_reload(16'h0005); wr(2'd0, 8'h13);
    tick(0, 1); rd_cnt(v); chk("R10 counting", v, 16'h0004);
    wr(2'd0, 8'h10); tick(0, 3); rd_cnt(v); chk("R10 stopped holds", v, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_start; t_select; t_reload; t_oneshot_flag;
    t_event; t_output; t_stop;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule